// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a small synchronous SRAM built so that reads and writes can be issued on any mix of consecutive cycles with no idle cycle between them. A command (valid, write flag, word address, byte enables) is sampled on a rising clock edge. Read data is returned, and write data is taken, a fixed number of cycles after the command. That number is the same for both directions, so a write issued right after a read puts its data on the bus exactly one cycle after the read data. The bus therefore never needs a turnaround gap.

A mode input picks the data latency. Low selects flow-through (one cycle). High selects pipelined (two cycles), which is also the mode after reset. A new mode value is only adopted while nothing is in flight. A sleep input puts the array into a retention state two cycles after it is raised. Leaving the state costs two wake-up cycles after the input falls. Commands seen while asleep or waking are dropped. Reads always see every write that was issued before them, even when that write's data has not yet reached the array.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted in every awake cycle, whatever the previous cycle held, so reads and writes can alternate with no idle cycle between them.
- R2: With `mode_q` in flow-through (`pipe_mode` sampled 0), a read issued in cycle c drives `rdata_oe`=1 with the word on `rdata_out` in cycle c+1.
- R3: In pipelined mode (`pipe_mode` sampled 1), a read issued in cycle c drives `rdata_oe`=1 with the word in cycle c+2.
- R4: The data of a write issued in cycle c is taken from `wdata_in` in cycle c+L, where L is 1 in flow-through and 2 in pipelined mode. `rdata_oe` is 0 in that cycle.
- R5: Bit i of `cmd_be` enables the write of bits [8i+7:8i]. A lane whose bit is 0 keeps its old value, and an all-zero mask changes nothing.
- R6: A read returns the word as updated by every write issued before it, including writes whose data arrives after the read was issued.
- R7: After reset `rdata_oe` is 0, the block is awake and the latency is pipelined.
- R8: If `sleep_req` is 1 in cycles c and c+1, the block is asleep in cycle c+2. Commands in cycles c and c+1 are still accepted. Commands from cycle c+2 on are ignored.
- R9: The array contents are unchanged across a sleep period.
- R10: If `sleep_req` falls to 0 in cycle k while asleep and stays 0, commands in cycles k, k+1 and k+2 are ignored. Commands are accepted again from cycle k+3.
- R11: A change of `pipe_mode` takes effect only at an edge where no command is accepted and no read or write is in flight. Operations already in flight keep the latency they started with.
- R12: An ignored command produces no read data and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 = pipelined (two-cycle), 0 = flow-through (one-cycle) |
| sleep_req | input | 1 | 1 requests retention sleep |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address |
| cmd_be | input | NUM_LANES | Byte-lane write mask |
| wdata_in | input | NUM_LANES*8 | Write data side of the bus |
| rdata_out | output | NUM_LANES*8 | Read data side of the bus, zero when not driven |
| rdata_oe | output | 1 | Read data valid / bus drive enable |

## Verification
The hardest case to reach is a read that lands between a write command and that write's data. The word the read returns must then be merged from an array value and bus data that arrive on different edges. The stimulus table issues write/read/write/read sequences in pipelined mode. It places the second write's data cycle both on the read's capture edge and on its stage-to-stage edge, with partial byte masks so that a wrong merge lane shows up. Sleep entry and exit are reached by holding `sleep_req` through commands that straddle both two-cycle windows. A read already in flight is let finish inside sleep. Afterwards the ignored writes are shown to have changed nothing.

// File: rtl/zt_pkg.sv
package zt_pkg;

  // Longest data latency (pipelined mode), in cycles after the command.
  localparam int MAX_LAT = 2;

  typedef enum logic [2:0] {
    SLP_AWAKE  = 3'd0,
    SLP_ENTER  = 3'd1,
    SLP_ASLEEP = 3'd2,
    SLP_WAKE1  = 3'd3,
    SLP_WAKE2  = 3'd4
  } slp_state_e;

  // Slot index a new write enters so that it commits after its data latency.
  function automatic int load_slot(input logic slow);
    return slow ? (MAX_LAT - 1) : 0;
  endfunction

endpackage

// File: rtl/zt_sleep_ctl.sv
module zt_sleep_ctl
  import zt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic cmd_ready
);

  slp_state_e state_q;
  slp_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLP_AWAKE:  state_d = sleep_req ? SLP_ENTER  : SLP_AWAKE;
      SLP_ENTER:  state_d = sleep_req ? SLP_ASLEEP : SLP_AWAKE;
      SLP_ASLEEP: state_d = sleep_req ? SLP_ASLEEP : SLP_WAKE1;
      SLP_WAKE1:  state_d = sleep_req ? SLP_ASLEEP : SLP_WAKE2;
      SLP_WAKE2:  state_d = sleep_req ? SLP_ASLEEP : SLP_AWAKE;
      default:    state_d = SLP_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLP_AWAKE;
    end else begin
      state_q <= state_d;
    end
  end

  assign cmd_ready = (state_q == SLP_AWAKE) || (state_q == SLP_ENTER);

endmodule

// File: rtl/zt_wr_sched.sv
module zt_wr_sched
  import zt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic                 push_slow,
  input  logic [ADDR_W-1:0]    push_addr,
  input  logic [NUM_LANES-1:0] push_be,
  output logic                 cmt_en,
  output logic [ADDR_W-1:0]    cmt_addr,
  output logic [NUM_LANES-1:0] cmt_be,
  output logic                 pend
);

  logic [MAX_LAT-1:0]                    slot_v_q, slot_v_d;
  logic [MAX_LAT-1:0][ADDR_W-1:0]        slot_a_q, slot_a_d;
  logic [MAX_LAT-1:0][NUM_LANES-1:0]     slot_b_q, slot_b_d;
  logic                                  slot_ce;
  int                                    ld_idx;

  assign ld_idx = load_slot(push_slow);

  always_comb begin
    slot_v_d = '0;
    slot_a_d = slot_a_q;
    slot_b_d = slot_b_q;
    for (int i = 0; i < MAX_LAT - 1; i++) begin
      slot_v_d[i] = slot_v_q[i+1];
      slot_a_d[i] = slot_a_q[i+1];
      slot_b_d[i] = slot_b_q[i+1];
    end
    if (push) begin
      slot_v_d[ld_idx] = 1'b1;
      slot_a_d[ld_idx] = push_addr;
      slot_b_d[ld_idx] = push_be;
    end
  end

  assign slot_ce = push || (|slot_v_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v_q <= '0;
    end else begin
      slot_v_q <= slot_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (slot_ce) begin
      slot_a_q <= slot_a_d;
      slot_b_q <= slot_b_d;
    end
  end

  assign cmt_en   = slot_v_q[0];
  assign cmt_addr = slot_a_q[0];
  assign cmt_be   = slot_b_q[0];
  assign pend     = |slot_v_q;

endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
  parameter int ADDR_W    = 4,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [NUM_LANES-1:0]        wr_be,
  input  logic [NUM_LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [NUM_LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;

    assign lane_we = wr_en && wr_be[g];

    always_ff @(posedge clk) begin
      if (lane_we) begin
        lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
  end

endmodule

// File: rtl/zt_rd_path.sv
module zt_rd_path #(
  parameter int ADDR_W    = 4,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_slow,
  input  logic                        cap,
  input  logic [ADDR_W-1:0]           cap_addr,
  input  logic [NUM_LANES*LANE_W-1:0] arr_data,
  input  logic                        cmt_en,
  input  logic [ADDR_W-1:0]           cmt_addr,
  input  logic [NUM_LANES-1:0]        cmt_be,
  input  logic [NUM_LANES*LANE_W-1:0] cmt_data,
  output logic [NUM_LANES*LANE_W-1:0] rdata_out,
  output logic                        rdata_oe,
  output logic                        rd_busy
);

  localparam int DW = NUM_LANES * LANE_W;

  // Overlay the lanes of a committing write onto a word already read.
  function automatic logic [DW-1:0] fold(input logic [DW-1:0] base,
                                         input logic            hit,
                                         input logic [NUM_LANES-1:0] be,
                                         input logic [DW-1:0]   nd);
    logic [DW-1:0] res;
    res = base;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (hit && be[l]) begin
        res[l*LANE_W +: LANE_W] = nd[l*LANE_W +: LANE_W];
      end
    end
    return res;
  endfunction

  logic              s0_v_q, s0_v_d;
  logic [ADDR_W-1:0] s0_a_q;
  logic [DW-1:0]     s0_d_q, s0_d_d;
  logic              s1_v_q, s1_v_d;
  logic [DW-1:0]     s1_d_q, s1_d_d;
  logic              s0_hit, s1_hit;
  logic              s0_ce, s1_ce;

  assign s0_hit = cmt_en && (cmt_addr == cap_addr);
  assign s1_hit = cmt_en && (cmt_addr == s0_a_q);

  always_comb begin
    s0_v_d = cap;
    s0_d_d = fold(arr_data, s0_hit, cmt_be, cmt_data);
    s1_v_d = s0_v_q && mode_slow;
    s1_d_d = fold(s0_d_q, s1_hit, cmt_be, cmt_data);
  end

  assign s0_ce = cap;
  assign s1_ce = s1_v_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_v_q <= 1'b0;
      s1_v_q <= 1'b0;
    end else begin
      s0_v_q <= s0_v_d;
      s1_v_q <= s1_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s0_ce) begin
      s0_a_q <= cap_addr;
      s0_d_q <= s0_d_d;
    end
    if (s1_ce) begin
      s1_d_q <= s1_d_d;
    end
  end

  always_comb begin
    if (mode_slow) begin
      rdata_oe  = s1_v_q;
      rdata_out = s1_v_q ? s1_d_q : '0;
    end else begin
      rdata_oe  = s0_v_q;
      rdata_out = s0_v_q ? s0_d_q : '0;
    end
  end

  assign rd_busy = s0_v_q || s1_v_q;

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W    = 4,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pipe_mode,
  input  logic                        sleep_req,
  input  logic                        cmd_valid,
  input  logic                        cmd_we,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [NUM_LANES-1:0]        cmd_be,
  input  logic [NUM_LANES*LANE_W-1:0] wdata_in,
  output logic [NUM_LANES*LANE_W-1:0] rdata_out,
  output logic                        rdata_oe
);

  localparam int DW = NUM_LANES * LANE_W;

  logic              cmd_ready;
  logic              accept;
  logic              mode_q;
  logic              mode_ce;
  logic              busy;
  logic              wr_pend;
  logic              rd_busy;
  logic              cmt_en;
  logic [ADDR_W-1:0] cmt_addr;
  logic [NUM_LANES-1:0] cmt_be;
  logic [DW-1:0]     arr_data;

  zt_sleep_ctl u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .cmd_ready (cmd_ready)
  );

  assign accept  = cmd_valid && cmd_ready;
  assign busy    = wr_pend || rd_busy;
  assign mode_ce = !busy && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
    end else if (mode_ce) begin
      mode_q <= pipe_mode;
    end
  end

  zt_wr_sched #(
    .ADDR_W    (ADDR_W),
    .NUM_LANES (NUM_LANES)
  ) u_wsched (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept && cmd_we),
    .push_slow (mode_q),
    .push_addr (cmd_addr),
    .push_be   (cmd_be),
    .cmt_en    (cmt_en),
    .cmt_addr  (cmt_addr),
    .cmt_be    (cmt_be),
    .pend      (wr_pend)
  );

  zt_lane_array #(
    .ADDR_W    (ADDR_W),
    .NUM_LANES (NUM_LANES),
    .LANE_W    (LANE_W)
  ) u_array (
    .clk     (clk),
    .wr_en   (cmt_en),
    .wr_addr (cmt_addr),
    .wr_be   (cmt_be),
    .wr_data (wdata_in),
    .rd_addr (cmd_addr),
    .rd_data (arr_data)
  );

  zt_rd_path #(
    .ADDR_W    (ADDR_W),
    .NUM_LANES (NUM_LANES),
    .LANE_W    (LANE_W)
  ) u_rpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_slow (mode_q),
    .cap       (accept && !cmd_we),
    .cap_addr  (cmd_addr),
    .arr_data  (arr_data),
    .cmt_en    (cmt_en),
    .cmt_addr  (cmt_addr),
    .cmt_be    (cmt_be),
    .cmt_data  (wdata_in),
    .rdata_out (rdata_out),
    .rdata_oe  (rdata_oe),
    .rd_busy   (rd_busy)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_we,
  input logic cmd_ready,
  input logic sleep_req,
  input logic rdata_oe,
  input logic mode_q,
  input logic busy
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  AST_FLOW_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_we && !mode_q |=> rdata_oe); // R2

  AST_PIPE_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_we && mode_q |-> ##2 rdata_oe); // R3

  AST_FLOW_WR_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_we && !mode_q |=> !rdata_oe); // R4

  AST_PIPE_WR_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_we && mode_q |-> ##2 !rdata_oe); // R4

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) && $past(sleep_req) && $past(sleep_req, 2) |-> !cmd_ready); // R8

  AST_WAKE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) && $rose(cmd_ready)
      |-> !$past(sleep_req) && !$past(sleep_req, 2) && !$past(sleep_req, 3)); // R10

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q)); // R11

endmodule

bind zt_sram zt_sram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_we    (cmd_we),
  .cmd_ready (cmd_ready),
  .sleep_req (sleep_req),
  .rdata_oe  (rdata_oe),
  .mode_q    (mode_q),
  .busy      (busy)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb;

  logic        clk;
  logic        rst_n;
  logic        pipe_mode;
  logic        sleep_req;
  logic        cmd_valid;
  logic        cmd_we;
  logic [3:0]  cmd_addr;
  logic [1:0]  cmd_be;
  logic [15:0] wdata_in;
  logic [15:0] rdata_out;
  logic        rdata_oe;

  int n_chk;
  int n_fail;
  bit done;

  zt_sram u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .sleep_req (sleep_req),
    .cmd_valid (cmd_valid),
    .cmd_we    (cmd_we),
    .cmd_addr  (cmd_addr),
    .cmd_be    (cmd_be),
    .wdata_in  (wdata_in),
    .rdata_out (rdata_out),
    .rdata_oe  (rdata_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        v;
    logic        we;
    logic [3:0]  a;
    logic [1:0]  be;
    logic [15:0] wd;
    logic        eo;
    logic [15:0] ed;
  } vec_t;

  // Pipelined-mode traffic, one row per cycle: command and bus data driven
  // in the cycle, expected read port in the same cycle.
  localparam vec_t TBL [0:12] = '{
    '{1'b1, 1'b1, 4'd1, 2'b11, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 4'd2, 2'b11, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 4'd1, 2'b00, 16'hA1B2, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 4'd1, 2'b01, 16'hC3D4, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 4'd1, 2'b00, 16'h0000, 1'b1, 16'hA1B2},
    '{1'b1, 1'b0, 4'd2, 2'b00, 16'h00E5, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 4'd3, 2'b11, 16'h0000, 1'b1, 16'hA1E5},
    '{1'b1, 1'b0, 4'd3, 2'b00, 16'h0000, 1'b1, 16'hC3D4},
    '{1'b1, 1'b1, 4'd3, 2'b10, 16'h5A6B, 1'b0, 16'h0000},
    '{1'b1, 1'b0, 4'd3, 2'b00, 16'h0000, 1'b1, 16'h5A6B},
    '{1'b0, 1'b0, 4'd0, 2'b00, 16'hFF11, 1'b0, 16'h0000},
    '{1'b0, 1'b0, 4'd0, 2'b00, 16'h0000, 1'b1, 16'hFF6B},
    '{1'b0, 1'b0, 4'd0, 2'b00, 16'h0000, 1'b0, 16'h0000}
  };

  task automatic check_port(input logic eo, input logic [15:0] ed, input string tag);
    n_chk++;
    if (rdata_oe !== eo || (eo && rdata_out !== ed)) begin
      n_fail++;
      $display("FAIL %s: oe=%b data=%h, expected oe=%b data=%h",
               tag, rdata_oe, rdata_out, eo, ed);
    end
  endtask

  // One cycle: check the read port, then drive this cycle's inputs.
  task automatic cyc(input logic v, input logic we, input logic [3:0] a,
                     input logic [1:0] be, input logic [15:0] wd, input logic sl,
                     input logic eo, input logic [15:0] ed, input string tag);
    @(negedge clk);
    check_port(eo, ed, tag);
    cmd_valid = v;
    cmd_we    = we;
    cmd_addr  = a;
    cmd_be    = be;
    wdata_in  = wd;
    sleep_req = sl;
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    pipe_mode = 1'b1;
    sleep_req = 1'b0;
    cmd_valid = 1'b0;
    cmd_we = 1'b0;
    cmd_addr = '0;
    cmd_be = '0;
    wdata_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: quiet bus after reset
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0, 1'b0, 1'b0, 16'h0, "R7 reset");

    // R1 R3 R4 R6 R7: back-to-back pipelined traffic in default mode
    for (int i = 0; i < 13; i++) begin
      cyc(TBL[i].v, TBL[i].we, TBL[i].a, TBL[i].be, TBL[i].wd, 1'b0,
          TBL[i].eo, TBL[i].ed, "R1 R3 R4 R6 table");
    end

    // Switch to flow-through while idle (R11)
    pipe_mode = 1'b0;
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b0, 16'h0,    "R11 idle");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b0, 16'h0,    "R11 idle");
    cyc(1'b1, 1'b1, 4'd4, 2'b11, 16'h0,    1'b0, 1'b0, 16'h0,    "R2 idle");
    cyc(1'b1, 1'b0, 4'd4, 2'b00, 16'h1357, 1'b0, 1'b0, 16'h0,    "R4 flow write data cycle");
    cyc(1'b1, 1'b1, 4'd4, 2'b00, 16'h0,    1'b0, 1'b1, 16'h1357, "R2 flow latency");
    cyc(1'b1, 1'b0, 4'd4, 2'b00, 16'hFFFF, 1'b0, 1'b0, 16'h0,    "R4 flow bus free");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b1, 16'h1357, "R5 empty mask");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b0, 16'h0,    "R2 single beat");

    // Sleep entry, retention, wake-up (flow-through)
    cyc(1'b1, 1'b1, 4'd5, 2'b11, 16'h0,    1'b1, 1'b0, 16'h0,    "R8 entry");
    cyc(1'b1, 1'b0, 4'd4, 2'b00, 16'h2468, 1'b1, 1'b0, 16'h0,    "R8 entry");
    cyc(1'b1, 1'b1, 4'd4, 2'b11, 16'h0,    1'b1, 1'b1, 16'h1357, "R8 read before sleep");
    cyc(1'b1, 1'b0, 4'd4, 2'b00, 16'hDEAD, 1'b1, 1'b0, 16'h0,    "R12 asleep");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b1, 1'b0, 16'h0,    "R12 ignored read");
    cyc(1'b1, 1'b1, 4'd4, 2'b11, 16'h0,    1'b0, 1'b0, 16'h0,    "R10 wake");
    cyc(1'b1, 1'b1, 4'd4, 2'b11, 16'hBEEF, 1'b0, 1'b0, 16'h0,    "R10 wake");
    cyc(1'b1, 1'b0, 4'd4, 2'b00, 16'hBEEF, 1'b0, 1'b0, 16'h0,    "R10 wake");
    cyc(1'b1, 1'b0, 4'd5, 2'b00, 16'hBEEF, 1'b0, 1'b0, 16'h0,    "R10 last ignored read");
    cyc(1'b1, 1'b0, 4'd4, 2'b00, 16'h0,    1'b0, 1'b1, 16'h2468, "R9 retention");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b1, 16'h1357, "R12 ignored writes");

    // Mode change requested while a read is in flight (R11), then pipelined (R3)
    pipe_mode = 1'b1;
    cyc(1'b1, 1'b0, 4'd4, 2'b00, 16'h0,    1'b0, 1'b0, 16'h0,    "R11 issue");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b1, 16'h1357, "R11 old latency kept");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b0, 16'h0,    "R11 drain");
    cyc(1'b1, 1'b0, 4'd5, 2'b00, 16'h0,    1'b0, 1'b0, 16'h0,    "R11 drain");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b0, 16'h0,    "R3 not yet");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b1, 16'h2468, "R3 pipelined latency");
    cyc(1'b0, 1'b0, 4'd0, 2'b00, 16'h0,    1'b0, 1'b0, 16'h0,    "R3 single beat");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule